// File: doc/BRIEF.md
# Queued SPI Interrupt and Error Control

This block holds the control and status logic of a queued SPI master. The master works through a list of commands kept in an internal RAM. A CPU starts the queue by setting a run bit. It sets the first and last command slots, and it can ask the queue to stop after the current command or to loop back to the start. A serial engine, which is not part of this block, runs one command at a time. It pulses a completion strobe when each command ends. The block tells the engine which slot to run, and it outputs the command byte stored in that slot.

The RAM is reached indirectly. Software writes a location number to an address register, then reads or writes that location through a data register. The RAM has 48 locations: locations 0 to 15 are transmit words, 16 to 31 are receive words, and 32 to 47 are the command bytes.

The block watches for three events and keeps a sticky flag for each:
- the queue finishes;
- software stops a running queue (an abort);
- software writes the command slot that is executing at that moment (a collision).

Each flag has its own interrupt enable, and the block drives one interrupt request. Separate guard bits can make an abort or a collision return a bus error and refuse the write. Another guard bit locks out aborts completely.

Top module: `qspi_irq_ctl`

Register map (`bus_addr`):
- 0 CTRL: bit 0 is the run bit.
- 1 QUEUE: bits [3:0] are the start slot, bits [7:4] the end slot, bit 8 is halt, bit 9 is wrap.
- 2 STAT:
  - flags: bit 0 finished, bit 1 abort, bit 2 collision;
  - interrupt enables: bits [6:4], in the same order as the flags;
  - guards: bit 8 collision-error enable, bit 9 abort-error enable, bit 10 abort lock.
- 3 ADDR: bits [5:0] select the RAM location.
- 4 DATA: the RAM location selected by ADDR.

## Requirements
- R1: After reset, every flag, enable, guard and pointer is zero. The run bit is 0 and `irq` is low.
- R2: Writing CTRL with bit 0 = 1 while idle starts the queue at the start slot. `eng_idx` then steps up by one on each `eng_done` and wraps from 15 to 0. While idle, `eng_done` has no effect.
- R3: Without wrap, completion of the end slot sets the finished flag (STAT bit 0) and clears the run bit.
- R4: With wrap (QUEUE bit 9), completion of the end slot sets the finished flag, reloads the start slot and keeps the run bit set.
- R5: With halt (QUEUE bit 8) set, the next completion sets the finished flag and clears the run bit, whatever the slot.
- R6: Writing CTRL bit 0 = 0 while running clears the run bit and sets the abort flag (STAT bit 1). The same write while idle sets nothing.
- R7: With abort lock (STAT bit 10) set, a CTRL write of 0 leaves the run bit set and does not set the abort flag.
- R8: With abort-error enable (STAT bit 9) set, a CTRL write of 0 while running asserts `bus_err` in that cycle and is refused: the queue keeps running.
- R9: While running, a DATA write with ADDR = 32 + `eng_idx` sets the collision flag (STAT bit 2) and stores the data. Command locations keep only 8 bits; other locations keep 16 bits.
- R10: With collision-error enable (STAT bit 8) set, a colliding DATA write asserts `bus_err` and is discarded. DATA writes that do not collide still succeed with no error.
- R11: Writing 1 to a STAT flag bit clears that flag; writing 0 leaves it. If a flag is set and cleared in the same cycle, the set wins.
- R12: `irq` is high exactly when some flag is set together with its enable in STAT bits [6:4].
- R13: Reserved bits read 0. STAT reads back only bits [10:8], [6:4] and [2:0]; QUEUE reads back only bits [9:0]. DATA reads 0 for locations 48 and above, and writes to those locations are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| bus_err | output | 1 | Access error for the current write |
| eng_done | input | 1 | The serial engine has completed the current command |
| eng_active | output | 1 | Queue running (the run bit) |
| eng_idx | output | 4 | Slot of the command now executing |
| eng_cmd | output | 8 | Command byte of the current slot |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases:
- A finish coinciding with a write-1-to-clear. A design where the clear wins loses the event and reads STAT as 0.
- The wrap path: a queue spanning slots 14 to 1 must cross 15 to 0 and reload slot 14. A design that stops there, or counts on to 2, diverges from the reference model on `eng_active` or `eng_idx`.
- Abort lock and abort-error enable. Each must keep the run bit set without setting the abort flag, and only the error case may raise `bus_err`.
- A refused collision write. It must leave the stored command byte unchanged, while a write to the neighbouring slot still succeeds.

// File: rtl/qspi_ctl_pkg.sv
package qspi_ctl_pkg;

   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
   localparam logic [REG_AW-1:0] RA_QUEUE = 3'd1;
   localparam logic [REG_AW-1:0] RA_STAT  = 3'd2;
   localparam logic [REG_AW-1:0] RA_ADDR  = 3'd3;
   localparam logic [REG_AW-1:0] RA_DATA  = 3'd4;

   localparam int NEV    = 3;
   localparam int EV_FIN = 0;
   localparam int EV_ABT = 1;
   localparam int EV_COL = 2;

   localparam int STAT_IE_LSB    = 4;
   localparam int STAT_GUARD_LSB = 8;

   typedef struct packed {
      logic abt_lock;
      logic abt_err;
      logic col_err;
   } guard_t;

endpackage

// File: rtl/qspi_cmd_ram.sv
module qspi_cmd_ram #(
   parameter int DW     = 16,
   parameter int QDEPTH = 16,
   parameter int CMD_W  = 8,
   localparam int RAM_N    = 3 * QDEPTH,
   localparam int RAW      = $clog2(RAM_N),
   localparam int PTR_W    = $clog2(QDEPTH),
   localparam int CMD_BASE = 2 * QDEPTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [RAW-1:0]   waddr,
   input  logic [DW-1:0]    wdata,
   input  logic [RAW-1:0]   raddr,
   output logic [DW-1:0]    rdata,
   input  logic [PTR_W-1:0] cmd_idx,
   output logic [CMD_W-1:0] cmd_out
);

   logic [DW-1:0]  mem [RAM_N];
   logic [DW-1:0]  wmask;
   logic           w_in_range;
   logic [RAW-1:0] cmd_loc;

   generate
      if (CMD_W < DW) begin : g_narrow_cmd
         assign wmask = (waddr >= RAW'(CMD_BASE)) ?
                        {{(DW-CMD_W){1'b0}}, {CMD_W{1'b1}}} : {DW{1'b1}};
      end else begin : g_full_cmd
         assign wmask = {DW{1'b1}};
      end
   endgenerate

   assign w_in_range = (waddr < RAW'(RAM_N));
   assign cmd_loc    = RAW'(CMD_BASE) + RAW'(cmd_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RAM_N; i++) mem[i] <= '0;
      end else if (we && w_in_range) begin
         mem[waddr] <= wdata & wmask;
      end
   end

   always_comb begin
      rdata = '0;
      if (raddr < RAW'(RAM_N)) rdata = mem[raddr];
   end

   assign cmd_out = mem[cmd_loc][CMD_W-1:0];

endmodule

// File: rtl/qspi_queue_seq.sv
module qspi_queue_seq #(
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             stop_req,
   input  logic             stop_block,
   input  logic             done,
   input  logic [PTR_W-1:0] start_ptr,
   input  logic [PTR_W-1:0] end_ptr,
   input  logic             halt,
   input  logic             wrap,
   output logic             running,
   output logic [PTR_W-1:0] ptr,
   output logic             fin_evt,
   output logic             abt_evt
);

   logic             at_end;
   logic             last;
   logic             adv;
   logic [PTR_W-1:0] nxt;

   assign at_end  = (ptr == end_ptr);
   assign fin_evt = running & done & (halt | at_end);
   assign last    = running & done & (halt | (at_end & ~wrap));
   assign abt_evt = running & stop_req & ~stop_block;
   assign adv     = running & done & ~last;
   assign nxt     = (at_end & wrap) ? start_ptr : ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         ptr     <= '0;
      end else if (!running) begin
         if (go) begin
            running <= 1'b1;
            ptr     <= start_ptr;
         end
      end else begin
         if (abt_evt || last) running <= 1'b0;
         if (adv)             ptr     <= nxt;
      end
   end

   AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      running && done && halt |=> !running); // R5

   AST_LOCK_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      running && stop_req && stop_block && !done |=> running); // R7

   AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      running && done && at_end && wrap && !halt && !stop_req
      |=> running && ptr == $past(start_ptr)); // R4

   AST_IDLE_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !go |=> $stable(ptr)); // R2

endmodule

// File: rtl/qspi_event_flags.sv
module qspi_event_flags #(
   parameter int NEV = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] set_evt,
   input  logic [NEV-1:0] clr_req,
   input  logic [NEV-1:0] ie,
   output logic [NEV-1:0] flags,
   output logic           irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= set_evt | (flags & ~clr_req);
   end

   assign irq = |(flags & ie);

   generate
      for (genvar i = 0; i < NEV; i++) begin : g_chk
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags[i]); // R11
         AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[i] && !set_evt[i] |=> !flags[i]); // R11
         AST_HOLD_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !clr_req[i] |=> flags[i]); // R11
      end
   endgenerate

endmodule

// File: rtl/qspi_irq_ctl.sv
module qspi_irq_ctl
   import qspi_ctl_pkg::*;
#(
   parameter int DW     = 16,
   parameter int QDEPTH = 16,
   parameter int CMD_W  = 8,
   localparam int PTR_W    = $clog2(QDEPTH),
   localparam int RAM_N    = 3 * QDEPTH,
   localparam int RAW      = $clog2(RAM_N),
   localparam int CMD_BASE = 2 * QDEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              bus_err,
   input  logic              eng_done,
   output logic              eng_active,
   output logic [PTR_W-1:0]  eng_idx,
   output logic [CMD_W-1:0]  eng_cmd,
   output logic              irq
);

   generate
      if (QDEPTH != (1 << PTR_W)) begin : g_bad_depth
         $error("QDEPTH must be a power of two");
      end
      if (2 * PTR_W + 2 > DW) begin : g_bad_queue_fields
         $error("queue fields do not fit the data width");
      end
      if (STAT_GUARD_LSB + 3 > DW) begin : g_bad_stat
         $error("status fields do not fit the data width");
      end
      if (CMD_W > DW || RAW > DW) begin : g_bad_widths
         $error("command or address width exceeds the data width");
      end
   endgenerate

   logic             wr_ctrl, wr_queue, wr_stat, wr_addr, wr_data;
   logic [PTR_W-1:0] start_ptr, end_ptr;
   logic             halt, wrap;
   logic [NEV-1:0]   ie;
   guard_t           guard;
   logic [RAW-1:0]   ram_addr;
   logic             running;
   logic [PTR_W-1:0] ptr;
   logic             fin_evt, abt_evt;
   logic             go, stop_req, stop_block;
   logic             collision, col_err, abt_err;
   logic [NEV-1:0]   set_evt, clr_req, flags;
   logic [DW-1:0]    ram_rdata;
   logic [RAW-1:0]   cur_cmd_loc;

   assign wr_ctrl  = bus_sel & bus_wr & (bus_addr == RA_CTRL);
   assign wr_queue = bus_sel & bus_wr & (bus_addr == RA_QUEUE);
   assign wr_stat  = bus_sel & bus_wr & (bus_addr == RA_STAT);
   assign wr_addr  = bus_sel & bus_wr & (bus_addr == RA_ADDR);
   assign wr_data  = bus_sel & bus_wr & (bus_addr == RA_DATA);

   // start / stop requests toward the sequencer
   assign go         = wr_ctrl & bus_wdata[0];
   assign stop_req   = wr_ctrl & ~bus_wdata[0] & running;
   assign stop_block = guard.abt_lock | guard.abt_err;
   assign abt_err    = stop_req & guard.abt_err;

   // write collision against the executing command slot
   assign cur_cmd_loc = RAW'(CMD_BASE) + RAW'(ptr);
   assign collision   = wr_data & running & (ram_addr == cur_cmd_loc);
   assign col_err     = collision & guard.col_err;

   assign bus_err = abt_err | col_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_ptr <= '0;
         end_ptr   <= '0;
         halt      <= 1'b0;
         wrap      <= 1'b0;
         ie        <= '0;
         guard     <= '0;
         ram_addr  <= '0;
      end else begin
         if (wr_queue) begin
            start_ptr <= bus_wdata[PTR_W-1:0];
            end_ptr   <= bus_wdata[2*PTR_W-1:PTR_W];
            halt      <= bus_wdata[2*PTR_W];
            wrap      <= bus_wdata[2*PTR_W+1];
         end
         if (wr_stat) begin
            ie    <= bus_wdata[STAT_IE_LSB +: NEV];
            guard <= bus_wdata[STAT_GUARD_LSB +: 3];
         end
         if (wr_addr) ram_addr <= bus_wdata[RAW-1:0];
      end
   end

   qspi_queue_seq #(.PTR_W(PTR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .stop_req   (stop_req),
      .stop_block (stop_block),
      .done       (eng_done),
      .start_ptr  (start_ptr),
      .end_ptr    (end_ptr),
      .halt       (halt),
      .wrap       (wrap),
      .running    (running),
      .ptr        (ptr),
      .fin_evt    (fin_evt),
      .abt_evt    (abt_evt)
   );

   always_comb begin
      set_evt         = '0;
      set_evt[EV_FIN] = fin_evt;
      set_evt[EV_ABT] = abt_evt;
      set_evt[EV_COL] = collision;
      clr_req         = wr_stat ? bus_wdata[NEV-1:0] : '0;
   end

   qspi_event_flags #(.NEV(NEV)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt),
      .clr_req (clr_req),
      .ie      (ie),
      .flags   (flags),
      .irq     (irq)
   );

   qspi_cmd_ram #(.DW(DW), .QDEPTH(QDEPTH), .CMD_W(CMD_W)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_data & ~col_err),
      .waddr   (ram_addr),
      .wdata   (bus_wdata),
      .raddr   (ram_addr),
      .rdata   (ram_rdata),
      .cmd_idx (ptr),
      .cmd_out (eng_cmd)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RA_CTRL:  bus_rdata[0] = running;
         RA_QUEUE: begin
            bus_rdata[PTR_W-1:0]       = start_ptr;
            bus_rdata[2*PTR_W-1:PTR_W] = end_ptr;
            bus_rdata[2*PTR_W]         = halt;
            bus_rdata[2*PTR_W+1]       = wrap;
         end
         RA_STAT: begin
            bus_rdata[NEV-1:0]                = flags;
            bus_rdata[STAT_IE_LSB +: NEV]     = ie;
            bus_rdata[STAT_GUARD_LSB +: 3]    = guard;
         end
         RA_ADDR:  bus_rdata[RAW-1:0] = ram_addr;
         RA_DATA:  bus_rdata = ram_rdata;
         default:  bus_rdata = '0;
      endcase
   end

   assign eng_active = running;
   assign eng_idx    = ptr;

   AST_ERR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_sel && bus_wr); // R8

   AST_ABORT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      eng_active && stop_req && !stop_block |=> !eng_active && flags[EV_ABT]); // R6

   AST_COLLISION_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      collision |=> flags[EV_COL]); // R9

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> |flags); // R12

endmodule

// File: tb/qspi_irq_ctl_test.sv
module qspi_irq_ctl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, eng_done = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_err, eng_active, irq;
   logic [3:0]  eng_idx;
   logic [7:0]  eng_cmd;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   qspi_irq_ctl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .eng_done(eng_done), .eng_active(eng_active),
      .eng_idx(eng_idx), .eng_cmd(eng_cmd), .irq(irq)
   );

   // ---------------- behavioural reference model ----------------
   bit m_run, m_halt, m_wrap, m_lock, m_aerr_en, m_cerr_en;
   int m_ptr, m_start, m_end, m_addr;
   bit [2:0] m_flag, m_ie;
   int m_ram [48];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_halt = 0; m_wrap = 0; m_lock = 0; m_aerr_en = 0; m_cerr_en = 0;
         m_ptr = 0; m_start = 0; m_end = 0; m_addr = 0; m_flag = 0; m_ie = 0;
         foreach (m_ram[i]) m_ram[i] = 0;
      end else begin
         bit w, stop_try, stop_ok, coll, cerr, fin, last;
         bit [2:0] setv, clrv;
         w        = bus_sel && bus_wr;
         stop_try = w && bus_addr == 0 && !bus_wdata[0] && m_run;
         stop_ok  = stop_try && !m_lock && !m_aerr_en;
         coll     = w && bus_addr == 4 && m_run && m_addr == 32 + m_ptr;
         cerr     = coll && m_cerr_en;
         fin      = eng_done && m_run && (m_halt || m_ptr == m_end);
         last     = eng_done && m_run && (m_halt || (m_ptr == m_end && !m_wrap));
         setv     = {coll, stop_ok, fin};
         clrv     = (w && bus_addr == 2) ? bus_wdata[2:0] : 3'b000;
         m_flag   = setv | (m_flag & ~clrv);
         if (!m_run) begin
            if (w && bus_addr == 0 && bus_wdata[0]) begin m_run = 1; m_ptr = m_start; end
         end else begin
            if (eng_done && !last)
               m_ptr = (m_ptr == m_end && m_wrap) ? m_start : (m_ptr + 1) % 16;
            if (stop_ok || last) m_run = 0;
         end
         if (w && bus_addr == 4 && !cerr && m_addr < 48)
            m_ram[m_addr] = (m_addr >= 32) ? (bus_wdata & 16'h00FF) : bus_wdata;
         if (w && bus_addr == 1) begin
            m_start = bus_wdata[3:0]; m_end = bus_wdata[7:4];
            m_halt = bus_wdata[8]; m_wrap = bus_wdata[9];
         end
         if (w && bus_addr == 2) begin
            m_ie = bus_wdata[6:4];
            m_cerr_en = bus_wdata[8]; m_aerr_en = bus_wdata[9]; m_lock = bus_wdata[10];
         end
         if (w && bus_addr == 3) m_addr = bus_wdata[5:0];
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // every-clock comparison of the registered outputs against the model
   bit cmp_on = 0;
   always @(negedge clk) begin
      if (cmp_on) begin
         check("R2/R3", "eng_active", int'(eng_active), int'(m_run));
         check("R2", "eng_idx", int'(eng_idx), m_ptr);
         check("R12", "irq", int'(irq), int'(|(m_flag & m_ie)));
         check("R9", "eng_cmd", int'(eng_cmd), m_ram[32 + m_ptr] & 255);
      end
   end

   task automatic cyc(input bit s, input bit w, input int a, input int d,
                      input bit dn, input bit exp_err, input string req);
      @(negedge clk);
      #2;
      bus_sel = s; bus_wr = w; bus_addr = a[2:0]; bus_wdata = d[15:0]; eng_done = dn;
      #1;
      check(req, "bus_err", int'(bus_err), int'(exp_err));
      @(posedge clk);
      #1;
      bus_sel = 0; bus_wr = 0; eng_done = 0;
   endtask

   task automatic wr(input int a, input int d, input bit exp_err, input string req);
      cyc(1, 1, a, d, 0, exp_err, req);
   endtask

   task automatic done1();
      cyc(0, 0, 0, 0, 1, 0, "R2");
   endtask

   task automatic rd(input int a, input int exp, input string req);
      @(negedge clk);
      #2;
      bus_sel = 1; bus_wr = 0; bus_addr = a[2:0];
      #1;
      check(req, "bus_rdata", int'(bus_rdata), exp);
      @(posedge clk);
      #1;
      bus_sel = 0;
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      cmp_on = 1;

      rd(2, 16'h0000, "R1");
      rd(0, 16'h0000, "R1");
      check("R1", "irq", int'(irq), 0);

      wr(2, 16'hFFFF, 0, "R13");
      rd(2, 16'h0770, "R13");
      wr(2, 16'h0000, 0, "R13");
      wr(1, 16'hFFFF, 0, "R13");
      rd(1, 16'h03FF, "R13");

      // plain queue 3..5
      wr(1, 16'h0053, 0, "R2");
      done1();                          // idle: ignored
      check("R2", "idle idx", int'(eng_idx), 0);
      wr(0, 1, 0, "R2");
      rd(0, 1, "R2");
      check("R2", "start idx", int'(eng_idx), 3);
      done1(); done1();
      check("R2", "idx after two", int'(eng_idx), 5);
      done1();
      rd(2, 16'h0001, "R3");
      rd(0, 0, "R3");

      wr(2, 16'h0000, 0, "R11");
      rd(2, 16'h0001, "R11");
      wr(2, 16'h0001, 0, "R11");
      rd(2, 16'h0000, "R11");

      // wrap queue 14..1
      wr(1, 16'h021E, 0, "R4");
      wr(0, 1, 0, "R4");
      check("R4", "start idx", int'(eng_idx), 14);
      done1(); done1();
      check("R2", "idx 15->0", int'(eng_idx), 0);
      done1(); done1();
      rd(0, 1, "R4");
      check("R4", "reload idx", int'(eng_idx), 14);
      rd(2, 16'h0001, "R4");

      wr(2, 16'h0010, 0, "R12");
      check("R12", "irq fin", int'(irq), 1);
      wr(2, 16'h0011, 0, "R12");
      check("R12", "irq cleared", int'(irq), 0);

      // halt while running
      wr(1, 16'h031E, 0, "R5");
      done1();
      rd(0, 0, "R5");
      rd(2, 16'h0011, "R5");
      check("R5", "irq halt", int'(irq), 1);
      wr(2, 16'h0001, 0, "R5");

      // set wins over clear
      wr(1, 16'h0010, 0, "R11");
      wr(0, 1, 0, "R11");
      done1();
      cyc(1, 1, 2, 16'h0001, 1, 0, "R11");
      rd(2, 16'h0001, "R11");
      wr(2, 16'h0001, 0, "R11");

      // abort
      wr(0, 0, 0, "R6");
      rd(2, 16'h0000, "R6");
      wr(1, 16'h00F0, 0, "R6");
      wr(0, 1, 0, "R6");
      wr(0, 0, 0, "R6");
      rd(0, 0, "R6");
      rd(2, 16'h0002, "R6");
      wr(2, 16'h0002, 0, "R6");

      // lock
      wr(2, 16'h0400, 0, "R7");
      wr(0, 1, 0, "R7");
      wr(0, 0, 0, "R7");
      rd(0, 1, "R7");
      rd(2, 16'h0400, "R7");

      // abort error
      wr(2, 16'h0200, 0, "R8");
      wr(0, 0, 1, "R8");
      rd(0, 1, "R8");
      rd(2, 16'h0200, "R8");

      // collision
      wr(2, 16'h0040, 0, "R9");
      wr(3, 32, 0, "R9");
      wr(4, 16'h12AB, 0, "R9");
      rd(4, 16'h00AB, "R9");
      check("R9", "eng_cmd", int'(eng_cmd), 8'hAB);
      rd(2, 16'h0044, "R9");
      check("R12", "irq coll", int'(irq), 1);

      wr(2, 16'h0144, 0, "R10");
      rd(2, 16'h0140, "R10");
      wr(4, 16'h0055, 1, "R10");
      rd(4, 16'h00AB, "R10");
      rd(2, 16'h0144, "R10");
      wr(3, 33, 0, "R10");
      wr(4, 16'h0066, 0, "R10");
      rd(4, 16'h0066, "R10");
      wr(3, 5, 0, "R9");
      wr(4, 16'hBEEF, 0, "R9");
      rd(4, 16'hBEEF, "R9");

      wr(3, 50, 0, "R13");
      wr(4, 16'h1234, 0, "R13");
      rd(4, 16'h0000, "R13");
      rd(3, 50, "R13");

      @(negedge clk);
      cmp_on = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule